// File: doc/BRIEF.md
# SMBus Host Status and Interrupt Sequencer

This block holds the status byte of an SMBus host controller. The bus engine reports events to it: a transaction starts, a byte moves, a transfer completes, a collision, a kill request, one of three device-error causes, and the alert pin. The block records each event in a sticky status bit. Software reads the byte and clears individual bits by writing a 1 to them. The block also drives an interrupt request, a clock-hold line back to the engine and a software ownership semaphore.

For block transfers without the 32-byte buffer, every transferred byte raises the byte-done bit, and the SCL line is held low while that bit is pending. On the final byte the completion bit is deferred. It rises only after software has cleared byte-done, so the interrupt line drops for one cycle between the two. An n-byte block therefore produces n+1 distinct interrupt edges.

Top module: `smb_hstat_seq`

## Requirements
- R1: Status bit layout: 0 busy, 1 completion, 2 byte-done, 3 device error, 4 bus error, 5 failed, 6 alert, 7 in-use. A register write with a 1 in bit positions 0 to 6 clears that bit, except as R10 and R12 state. A 0 in a position leaves that bit unchanged.
- R2: With `buf_en` low, a byte event (`evt_byte` high, `evt_hbeat` low) sets byte-done at the next edge. This includes a byte flagged `evt_last`.
- R3: A last byte with `buf_en` low does not set completion. Completion is set at the edge one cycle after byte-done is first seen clear, and that byte-done bit must have been set together with the last byte. An n-byte block gives n+1 rising edges on `irq`.
- R4: `scl_hold` is high exactly when byte-done is set and `buf_en` is low.
- R5: A byte event with `evt_hbeat` high changes no status bit. With `buf_en` high, a byte event leaves byte-done clear. A last byte then sets completion at the next edge. `evt_cmpl` sets completion at the next edge.
- R6: Bit 7 and `in_use` read 0 until the first register read after reset, and 1 after any read. A write with bit 7 set returns them to 0 and wins over a read in the same cycle. A write with bit 7 clear does nothing to them.
- R7: The alert bit is set while `alert_n` is low and `alert_gpio` is low. It is never set while `alert_gpio` is high. It is cleared only by a W1C write or by `rsm_rst_n` low; `rst_n` does not clear it.
- R8: `evt_kill` sets the failed bit and `evt_coll` sets the bus-error bit at the next edge.
- R9: Any of `cause_badcmd`, `cause_unclaim` or `cause_tmo` sets the device-error bit at the next edge.
- R10: `evt_start` sets busy. A write clearing busy takes effect only if byte-done was clear before that write.
- R11: `irq` is high when any of completion, byte-done, device error, bus error, failed or alert is set.
- R12: When a hardware set and a W1C write hit the same bit in one cycle, the bit stays set.
- R13: While `rst_n` is low, every status bit except alert is 0, and the hidden pending-completion state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low main reset |
| rsm_rst_n | input | 1 | Asynchronous active-low resume reset, alert bit only |
| buf_en | input | 1 | 32-byte buffer in use for the block transfer |
| evt_start | input | 1 | Host transaction started |
| evt_byte | input | 1 | One byte of a block transfer moved |
| evt_last | input | 1 | Qualifies `evt_byte` as the final byte |
| evt_hbeat | input | 1 | Qualifies `evt_byte` as a heartbeat transmission |
| evt_cmpl | input | 1 | Non-deferred completion of a transaction |
| evt_coll | input | 1 | Bus collision detected |
| evt_kill | input | 1 | Transaction terminated by kill request |
| cause_badcmd | input | 1 | Invalid command field |
| cause_unclaim | input | 1 | Host cycle not claimed by a device |
| cause_tmo | input | 1 | Device timeout |
| alert_n | input | 1 | Alert pin, active low |
| alert_gpio | input | 1 | Alert pin configured as general-purpose I/O |
| reg_rd | input | 1 | Status register read strobe |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Write data, 1 means clear (bit 7: release semaphore) |
| status | output | 8 | Status byte, valid as read data |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Hold SCL low in the bus engine |
| in_use | output | 1 | Ownership semaphore value |

## Verification
Two pairs of functions can collide in one cycle. A hardware set can land on the same bit as a W1C write. A busy-clear write can arrive in the same cycle as, or while, byte-done is pending. Directed cases force each collision on a chosen cycle: a collision with a bus-error clear, a new byte with a byte-done clear, a busy clear with a pending byte. Long random runs then keep strobes and writes overlapping freely. Every cycle the status byte, `irq`, `scl_hold` and `in_use` are compared with a bench model built from the requirements. A separate counter of `irq` rising edges judges the n+1 interrupt ordering.

// File: rtl/smb_hstat_pkg.sv
package smb_hstat_pkg;
    localparam int STAT_W  = 8;
    localparam int B_BUSY  = 0;
    localparam int B_CMPL  = 1;
    localparam int B_BDONE = 2;
    localparam int B_DEVE  = 3;
    localparam int B_BUSE  = 4;
    localparam int B_FAIL  = 5;
    localparam int B_ALRT  = 6;
    localparam int B_INUSE = 7;
    localparam int NERR    = 3;       // device error, bus error, failed
    localparam int ERR_LSB = B_DEVE;

    typedef struct packed {
        logic busy;
        logic cmpl;
        logic bdone;
        logic pend;
    } xfer_st_t;
endpackage

// File: rtl/smb_w1c_bits.sv
module smb_w1c_bits #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] bits_d, bits_q;

    always_comb begin
        // hardware set wins over a simultaneous software clear
        bits_d = set_i | (bits_q & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign q_o = bits_q;
endmodule

// File: rtl/smb_sem_unit.sv
module smb_sem_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    input  logic rel_i,
    output logic sem_o
);
    logic sem_d, sem_q;

    always_comb begin
        sem_d = sem_q;
        if (rel_i)     sem_d = 1'b0;
        else if (rd_i) sem_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sem_q <= 1'b0;
        else        sem_q <= sem_d;
    end

    assign sem_o = sem_q;
endmodule

// File: rtl/smb_xfer_seq.sv
module smb_xfer_seq
    import smb_hstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic buf_en,
    input  logic evt_start,
    input  logic evt_byte,
    input  logic evt_last,
    input  logic evt_hbeat,
    input  logic evt_cmpl,
    input  logic clr_busy,
    input  logic clr_cmpl,
    input  logic clr_bdone,
    output logic busy_o,
    output logic cmpl_o,
    output logic bdone_o
);
    xfer_st_t st_d, st_q;
    logic     byte_ok, bd_set, fin_now;

    always_comb begin
        st_d    = st_q;
        byte_ok = evt_byte & ~evt_hbeat;
        bd_set  = byte_ok & ~buf_en;
        // deferred completion fires once the byte-done bit is seen clear
        fin_now = evt_cmpl | (byte_ok & evt_last & buf_en) | (st_q.pend & ~st_q.bdone);

        st_d.bdone = bd_set | (st_q.bdone & ~clr_bdone);
        if (bd_set && evt_last)             st_d.pend = 1'b1;
        else if (st_q.pend && !st_q.bdone)  st_d.pend = 1'b0;
        st_d.cmpl = fin_now | (st_q.cmpl & ~clr_cmpl);
        st_d.busy = evt_start | (st_q.busy & ~(clr_busy & ~st_q.bdone));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o  = st_q.busy;
    assign cmpl_o  = st_q.cmpl;
    assign bdone_o = st_q.bdone;
endmodule

// File: rtl/smb_hstat_seq.sv
module smb_hstat_seq
    import smb_hstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsm_rst_n,
    input  logic              buf_en,
    input  logic              evt_start,
    input  logic              evt_byte,
    input  logic              evt_last,
    input  logic              evt_hbeat,
    input  logic              evt_cmpl,
    input  logic              evt_coll,
    input  logic              evt_kill,
    input  logic              cause_badcmd,
    input  logic              cause_unclaim,
    input  logic              cause_tmo,
    input  logic              alert_n,
    input  logic              alert_gpio,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    output logic              scl_hold,
    output logic              in_use
);
    logic [STAT_W-1:0] clr_vec;
    logic [NERR-1:0]   err_set, err_q;
    logic              busy, cmpl, bdone, alrt, sem;

    assign clr_vec = reg_wr ? reg_wdata : '0;

    smb_xfer_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_en    (buf_en),
        .evt_start (evt_start),
        .evt_byte  (evt_byte),
        .evt_last  (evt_last),
        .evt_hbeat (evt_hbeat),
        .evt_cmpl  (evt_cmpl),
        .clr_busy  (clr_vec[B_BUSY]),
        .clr_cmpl  (clr_vec[B_CMPL]),
        .clr_bdone (clr_vec[B_BDONE]),
        .busy_o    (busy),
        .cmpl_o    (cmpl),
        .bdone_o   (bdone)
    );

    always_comb begin
        err_set[B_DEVE - ERR_LSB] = cause_badcmd | cause_unclaim | cause_tmo;
        err_set[B_BUSE - ERR_LSB] = evt_coll;
        err_set[B_FAIL - ERR_LSB] = evt_kill;
    end

    smb_w1c_bits #(.N(NERR)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (err_set),
        .clr_i (clr_vec[ERR_LSB +: NERR]),
        .q_o   (err_q)
    );

    // alert lives in the resume well: only the resume reset clears it
    smb_w1c_bits #(.N(1)) u_alrt (
        .clk   (clk),
        .rst_n (rsm_rst_n),
        .set_i (~alert_n & ~alert_gpio),
        .clr_i (clr_vec[B_ALRT]),
        .q_o   (alrt)
    );

    smb_sem_unit u_sem (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_i  (reg_rd),
        .rel_i (clr_vec[B_INUSE]),
        .sem_o (sem)
    );

    always_comb begin
        status                    = '0;
        status[B_BUSY]            = busy;
        status[B_CMPL]            = cmpl;
        status[B_BDONE]           = bdone;
        status[ERR_LSB +: NERR]   = err_q;
        status[B_ALRT]            = alrt;
        status[B_INUSE]           = sem;
    end

    assign irq      = cmpl | bdone | (|err_q) | alrt;
    assign scl_hold = bdone & ~buf_en;
    assign in_use   = sem;
endmodule

// File: rtl/smb_hstat_chk.sv
module smb_hstat_chk
    import smb_hstat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              buf_en,
    input logic              evt_byte,
    input logic              evt_last,
    input logic              evt_hbeat,
    input logic              evt_cmpl,
    input logic              evt_coll,
    input logic              evt_kill,
    input logic              cause_badcmd,
    input logic              cause_unclaim,
    input logic              cause_tmo,
    input logic              reg_wr,
    input logic [STAT_W-1:0] reg_wdata,
    input logic [STAT_W-1:0] status,
    input logic              scl_hold
);
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[B_BUSE] && status[B_BUSE]) |=> status[B_BUSE]); // R1

    AST_BYTE_SETS_BD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_byte && !evt_hbeat && !buf_en) |=> status[B_BDONE]); // R2

    AST_NO_EARLY_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_BDONE] && !evt_cmpl && !(evt_byte && evt_last && buf_en && !evt_hbeat))
        |=> !$rose(status[B_CMPL])); // R3

    AST_HOLD_WITH_BD: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> (status[B_BDONE] && !buf_en)); // R4

    AST_COLL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_coll |=> status[B_BUSE]); // R12

    AST_KILL_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_kill |=> status[B_FAIL]); // R8

    AST_DEV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_badcmd || cause_unclaim || cause_tmo) |=> status[B_DEVE]); // R9

    AST_BUSY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_BUSY] && status[B_BDONE]) |=> status[B_BUSY]); // R10
endmodule

bind smb_hstat_seq smb_hstat_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .buf_en        (buf_en),
    .evt_byte      (evt_byte),
    .evt_last      (evt_last),
    .evt_hbeat     (evt_hbeat),
    .evt_cmpl      (evt_cmpl),
    .evt_coll      (evt_coll),
    .evt_kill      (evt_kill),
    .cause_badcmd  (cause_badcmd),
    .cause_unclaim (cause_unclaim),
    .cause_tmo     (cause_tmo),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .status        (status),
    .scl_hold      (scl_hold)
);

// File: tb/sim_smb_hstat_seq.sv
module sim_smb_hstat_seq;
    typedef struct packed {
        logic       buf_en, start, byt, last, hb, cmpl, coll, kill;
        logic       badcmd, unclaim, tmo, alert_n, gpio, rd, wr;
        logic [7:0] wd;
    } in_t;

    typedef struct packed {
        logic [7:0] st;
        logic       pend;
    } mdl_t;

    logic       clk = 0, rst_n = 0, rsm_rst_n = 0;
    logic       buf_en = 0, evt_start = 0, evt_byte = 0, evt_last = 0, evt_hbeat = 0;
    logic       evt_cmpl = 0, evt_coll = 0, evt_kill = 0;
    logic       cause_badcmd = 0, cause_unclaim = 0, cause_tmo = 0;
    logic       alert_n = 1, alert_gpio = 0, reg_rd = 0, reg_wr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] status;
    logic       irq, scl_hold, in_use;

    int   checks = 0, fails = 0, irq_edges = 0;
    logic irq_prev = 0;
    mdl_t mdl = '0;
    in_t  cur_buf = '0;

    always #10 clk = ~clk;   // 50 MHz

    smb_hstat_seq u0 (
        .clk(clk), .rst_n(rst_n), .rsm_rst_n(rsm_rst_n), .buf_en(buf_en),
        .evt_start(evt_start), .evt_byte(evt_byte), .evt_last(evt_last),
        .evt_hbeat(evt_hbeat), .evt_cmpl(evt_cmpl), .evt_coll(evt_coll),
        .evt_kill(evt_kill), .cause_badcmd(cause_badcmd), .cause_unclaim(cause_unclaim),
        .cause_tmo(cause_tmo), .alert_n(alert_n), .alert_gpio(alert_gpio),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .status(status), .irq(irq), .scl_hold(scl_hold), .in_use(in_use)
    );

    function automatic string bit_req(input int b);
        case (b)
            0: return "R10";
            1: return "R3";
            2: return "R2";
            3: return "R9";
            4: return "R8";
            5: return "R8";
            6: return "R7";
            default: return "R6";
        endcase
    endfunction

    function automatic mdl_t model_next(input mdl_t m, input in_t i);
        mdl_t       n = m;
        logic [7:0] clr = i.wr ? i.wd : 8'h00;
        logic [7:0] set = 8'h00;
        logic       ok = i.byt & ~i.hb;
        logic       bds = ok & ~i.buf_en;
        set[0] = i.start;
        set[1] = i.cmpl | (ok & i.last & i.buf_en) | (m.pend & ~m.st[2]);
        set[2] = bds;
        set[3] = i.badcmd | i.unclaim | i.tmo;
        set[4] = i.coll;
        set[5] = i.kill;
        set[6] = ~i.alert_n & ~i.gpio;
        if (m.st[2]) clr[0] = 1'b0;          // busy clear blocked by pending byte-done
        n.st[6:0] = set[6:0] | (m.st[6:0] & ~clr[6:0]);
        n.st[7]   = clr[7] ? 1'b0 : (i.rd ? 1'b1 : m.st[7]);
        if (bds && i.last)          n.pend = 1'b1;
        else if (m.pend && !m.st[2]) n.pend = 1'b0;
        return n;
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [7:0] e = mdl.st;
        logic       eirq = |e[6:1];
        logic       ehold = e[2] & ~cur_buf.buf_en;
        string      r = "R1";
        for (int b = 7; b >= 0; b--) if (status[b] !== e[b]) r = bit_req(b);
        chk(status === e, r, "status", status, e);
        chk(irq === eirq, "R11", "irq", {7'b0, irq}, {7'b0, eirq});
        chk(scl_hold === ehold, "R4", "scl_hold", {7'b0, scl_hold}, {7'b0, ehold});
        chk(in_use === e[7], "R6", "in_use", {7'b0, in_use}, {7'b0, e[7]});
    endtask

    function automatic in_t idle(input logic be);
        in_t i = '0;
        i.alert_n = 1'b1;
        i.buf_en  = be;
        return i;
    endfunction

    task automatic drive(input in_t i);
        buf_en = i.buf_en; evt_start = i.start; evt_byte = i.byt; evt_last = i.last;
        evt_hbeat = i.hb; evt_cmpl = i.cmpl; evt_coll = i.coll; evt_kill = i.kill;
        cause_badcmd = i.badcmd; cause_unclaim = i.unclaim; cause_tmo = i.tmo;
        alert_n = i.alert_n; alert_gpio = i.gpio; reg_rd = i.rd; reg_wr = i.wr;
        reg_wdata = i.wd;
    endtask

    // called at a falling edge; applies inputs for one rising edge, then compares
    task automatic step(input in_t i);
        cur_buf = i;
        drive(i);
        @(posedge clk);
        @(negedge clk);
        mdl = model_next(mdl, i);
        drive(idle(i.buf_en));
        compare();
        if (irq && !irq_prev) irq_edges++;
        irq_prev = irq;
    endtask

    task automatic wr1(input logic be, input logic [7:0] d);
        in_t i = idle(be);
        i.wr = 1'b1; i.wd = d;
        step(i);
    endtask

    task automatic pulse_reset(input logic main_rst, input logic rsm_rst);
        if (main_rst) rst_n = 1'b0;
        if (rsm_rst)  rsm_rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; rsm_rst_n = 1'b1;
        if (main_rst) begin mdl.st[5:0] = '0; mdl.st[7] = 1'b0; mdl.pend = 1'b0; end
        if (rsm_rst)  mdl.st[6] = 1'b0;
        irq_prev = irq;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        in_t i;
        void'($urandom(32'd5150));
        @(negedge clk);
        @(negedge clk);
        // R13: reset state
        chk(status === 8'h00 && !irq && !scl_hold && !in_use, "R13", "reset",
            status, 8'h00);
        pulse_reset(1'b0, 1'b0);
        compare();

        // R6: semaphore sequence
        chk(status[7] === 1'b0, "R6", "first read value", status, 8'h00);
        i = idle(0); i.rd = 1; step(i);
        chk(status[7] === 1'b1, "R6", "after read", status, 8'h80);
        wr1(0, 8'h7F);                              // bit 7 zero: no effect
        chk(in_use === 1'b1, "R6", "write 0 keeps", {7'b0, in_use}, 8'h01);
        i = idle(0); i.rd = 1; i.wr = 1; i.wd = 8'h80; step(i);
        chk(in_use === 1'b0, "R6", "release wins", {7'b0, in_use}, 8'h00);

        // R3 R4 R10: three-byte block without buffer, count irq edges
        irq_edges = 0;
        i = idle(0); i.start = 1; step(i);
        for (int k = 0; k < 3; k++) begin
            i = idle(0); i.byt = 1; i.last = (k == 2); step(i);
            chk(scl_hold === 1'b1, "R4", "hold while pending", {7'b0, scl_hold}, 8'h01);
            chk(status[1] === 1'b0, "R3", "no early completion", status, 8'h04);
            wr1(0, 8'h01);                          // R10 busy clear blocked
            chk(status[0] === 1'b1, "R10", "busy kept", status, 8'h05);
            step(idle(0));
            wr1(0, 8'h04);
        end
        step(idle(0));
        chk(status[1] === 1'b1, "R3", "deferred completion", status, 8'h03);
        wr1(0, 8'h03);
        chk(status[1:0] === 2'b00, "R10", "busy cleared", status, 8'h00);
        chk(irq_edges == 4, "R3", "irq edges", 8'(irq_edges), 8'd4);

        // R12: collision set beside a clear of the same bit
        i = idle(0); i.coll = 1; step(i);
        i = idle(0); i.coll = 1; i.wr = 1; i.wd = 8'h10; step(i);
        chk(status[4] === 1'b1, "R12", "set wins", status, 8'h10);
        // new byte beside a byte-done clear
        i = idle(0); i.byt = 1; step(i);
        i = idle(0); i.byt = 1; i.wr = 1; i.wd = 8'h04; step(i);
        chk(status[2] === 1'b1, "R12", "byte-done set wins", status, 8'h04);
        wr1(0, 8'hFF);

        // R5: heartbeat and buffered transfers
        i = idle(0); i.byt = 1; i.hb = 1; i.last = 1; step(i);
        chk(status[2:1] === 2'b00, "R5", "heartbeat ignored", status, 8'h00);
        i = idle(1); i.byt = 1; step(i);
        chk(status[2] === 1'b0, "R5", "buffered byte", status, 8'h00);
        i = idle(1); i.byt = 1; i.last = 1; step(i);
        chk(status[1] === 1'b1, "R5", "buffered last", status, 8'h02);
        wr1(0, 8'hFF);

        // R7: alert, gpio mode, reset wells
        i = idle(0); i.alert_n = 0; i.gpio = 1; step(i);
        chk(status[6] === 1'b0, "R7", "gpio blocks", status, 8'h00);
        i = idle(0); i.alert_n = 0; step(i);
        pulse_reset(1'b1, 1'b0);
        compare();
        chk(status === 8'h40, "R7", "survives main reset", status, 8'h40);
        pulse_reset(1'b0, 1'b1);
        compare();
        chk(status === 8'h00, "R7", "resume reset", status, 8'h00);

        // R8 R9: error causes
        i = idle(0); i.kill = 1; i.tmo = 1; step(i);
        chk(status[5] && status[3], "R8", "kill and timeout", status, 8'h28);
        wr1(0, 8'h28);
        i = idle(0); i.unclaim = 1; step(i);
        chk(status[3] === 1'b1, "R9", "unclaimed", status, 8'h08);
        wr1(0, 8'h08);

        // random phase: R1 R11 and every bit against the model
        for (int n = 0; n < 4000; n++) begin
            i = idle(cur_buf.buf_en);
            if ($urandom_range(49) == 0) i.buf_en = ~i.buf_en;
            i.start   = ($urandom_range(19) == 0);
            i.byt     = ($urandom_range(3) == 0);
            i.last    = ($urandom_range(2) == 0);
            i.hb      = ($urandom_range(7) == 0);
            i.cmpl    = ($urandom_range(29) == 0);
            i.coll    = ($urandom_range(39) == 0);
            i.kill    = ($urandom_range(39) == 0);
            i.badcmd  = ($urandom_range(59) == 0);
            i.unclaim = ($urandom_range(59) == 0);
            i.tmo     = ($urandom_range(59) == 0);
            i.alert_n = ($urandom_range(39) != 0);
            i.gpio    = ($urandom_range(3) == 0);
            i.rd      = ($urandom_range(7) == 0);
            i.wr      = ($urandom_range(3) == 0);
            i.wd      = 8'($urandom);
            step(i);
        end
        finish_up();
    end
endmodule